// File: doc/BRIEF.md
# Speed-Loop Phase/Frequency Comparator

This block closes the digital part of a motor speed loop. It watches two slow signals in the system clock domain: an external reference clock and the feedback pulse taken from the first Hall sensor phase. A reference falling edge and a feedback rising edge are the two events being compared. Whichever event comes first opens an output pulse on its own side (`up_o` for a leading reference, `dn_o` for a leading feedback). The other event then closes that pulse. Each pulse therefore lasts exactly as many system clock cycles as the two edges are apart. The loop settles when the feedback runs at the reference frequency, one to one, with no divider in between.

Both inputs first pass through a synchronizer and a minimum-width filter, so chatter shorter than the filter length never reaches the comparator. Both paths have the same latency, so the edge separation seen at the outputs is exact. A raw lock flag rises once a run of consecutive comparisons has produced pulses narrower than a window set at a port. It falls as soon as any pulse grows to that window. Pulling `enable` low stops the comparator: both outputs go low and any half-finished comparison is dropped.

Top module: `spd_phase_cmp`

## Requirements
- R1: After reset, `up_o`, `dn_o` and `locked_o` are all low.
- R2: When a reference falling edge arrives with no comparison open, `up_o` goes high and stays high until the next feedback rising edge. Its width in cycles equals the separation of the two edges at the pins.
- R3: When a feedback rising edge arrives with no comparison open, `dn_o` goes high until the next reference falling edge. Its width equals the edge separation.
- R4: `up_o` and `dn_o` are never high together. A reference falling edge and a feedback rising edge that reach the comparator in the same cycle, with nothing open, produce no pulse.
- R5: Reference rising edges and feedback falling edges have no effect on either output.
- R6: An input level that is held for fewer than `FILT_LEN` consecutive cycles is rejected and produces no pulse.
- R7: While `enable` is low, both outputs and `locked_o` are low from the next cycle on. An open comparison is dropped, and edges seen meanwhile start nothing.
- R8: `locked_o` goes high after `LOCK_RUN` consecutive comparisons whose pulse width is below `lock_win_i` cycles. A coincident pair counts as width zero.
- R9: `locked_o` goes low once an output pulse reaches `lock_win_i` cycles, and the run count starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low stops and clears the comparator |
| ref_clk_i | input | 1 | Reference clock, compared on falling edges |
| fb_i | input | 1 | Motor feedback pulse, compared on rising edges |
| lock_win_i | input | CNT_W | Lock window in system clock cycles |
| up_o | output | 1 | High while the reference edge leads |
| dn_o | output | 1 | High while the feedback edge leads |
| locked_o | output | 1 | Raw in-lock indication |

## Verification
The hardest situations to reach from the pins are the timing corners. The first is two edges reaching the comparator in the very same cycle. The second is an input pulse that is exactly one cycle too short for the filter. The third is a pulse exactly one cycle wider than the lock window allows. The stimulus drives the inputs one nanosecond after a clock edge, so every hold time is an exact cycle count. This allows zero separation, `FILT_LEN-1` glitches and window-edge widths to be placed precisely. Random separations and leading sides, drawn from a seeded generator, are mixed in around these directed cases.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic {POL_FALL = 1'b0, POL_RISE = 1'b1} edge_pol_e;
endpackage

// File: rtl/spc_edge_filt.sv
module spc_edge_filt
   import spc_pkg::*;
#(
   parameter int        SYNC_STAGES = 2,
   parameter int        FILT_LEN    = 4,
   parameter edge_pol_e POL         = POL_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   localparam logic TGT = (POL == POL_RISE);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spc_edge_filt: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("spc_edge_filt: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp;
   logic                   lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign smp = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 1) begin : g_nofilt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q  <= 1'b0;
            edge_o <= 1'b0;
         end else begin
            lvl_q  <= smp;
            edge_o <= (smp != lvl_q) && (smp == TGT);
         end
      end
   end else begin : g_filt
      localparam int CW = $clog2(FILT_LEN);
      localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
      logic [CW-1:0] hold_q;
      logic          accept;
      assign accept = (smp != lvl_q) && (hold_q == LAST);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q  <= 1'b0;
            hold_q <= '0;
            edge_o <= 1'b0;
         end else begin
            edge_o <= accept && (smp == TGT);
            if (smp == lvl_q) begin
               hold_q <= '0;
            end else if (accept) begin
               lvl_q  <= smp;
               hold_q <= '0;
            end else begin
               hold_q <= hold_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/spc_pfd.sv
module spc_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ref_edge,
   input  logic fb_edge,
   output logic up,
   output logic dn,
   output logic close
);
   logic up_n, dn_n;

   always_comb begin
      up_n  = up;
      dn_n  = dn;
      close = 1'b0;
      if (ref_edge && !fb_edge) begin
         if (dn) begin
            dn_n  = 1'b0;
            close = 1'b1;
         end else begin
            up_n = 1'b1;
         end
      end else if (fb_edge && !ref_edge) begin
         if (up) begin
            up_n  = 1'b0;
            close = 1'b1;
         end else begin
            dn_n = 1'b1;
         end
      end else if (ref_edge && fb_edge) begin
         close = 1'b1;
      end
      if (!enable) begin
         up_n  = 1'b0;
         dn_n  = 1'b0;
         close = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up <= 1'b0;
         dn <= 1'b0;
      end else begin
         up <= up_n;
         dn <= dn_n;
      end
   end
endmodule

// File: rtl/spc_lock_det.sv
module spc_lock_det #(
   parameter int CNT_W    = 12,
   parameter int LOCK_RUN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             busy,
   input  logic             close,
   input  logic [CNT_W-1:0] win,
   output logic             locked
);
   localparam int RW = $clog2(LOCK_RUN + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);

   if (LOCK_RUN < 1) begin : g_bad_run
      $error("spc_lock_det: LOCK_RUN must be at least 1");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("spc_lock_det: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] wid_q;
   logic [RW-1:0]    run_q;
   logic             too_wide;

   assign too_wide = busy && (({1'b0, wid_q} + 1'b1) >= {1'b0, win});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wid_q <= '0;
         run_q <= '0;
      end else if (!enable) begin
         wid_q <= '0;
         run_q <= '0;
      end else begin
         if (close || !busy)     wid_q <= '0;
         else if (~&wid_q)       wid_q <= wid_q + 1'b1;
         if (too_wide)                    run_q <= '0;
         else if (close && run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end
   end

   assign locked = (run_q == RUN_MAX);
endmodule

// File: rtl/spd_phase_cmp.sv
module spd_phase_cmp
   import spc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter int CNT_W       = 12,
   parameter int LOCK_RUN    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             ref_clk_i,
   input  logic             fb_i,
   input  logic [CNT_W-1:0] lock_win_i,
   output logic             up_o,
   output logic             dn_o,
   output logic             locked_o
);
   logic ref_edge, fb_edge, close;

   spc_edge_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .POL(POL_FALL)) u_ref (
      .clk(clk), .rst_n(rst_n), .din(ref_clk_i), .edge_o(ref_edge));

   spc_edge_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .POL(POL_RISE)) u_fb (
      .clk(clk), .rst_n(rst_n), .din(fb_i), .edge_o(fb_edge));

   spc_pfd u_pfd (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ref_edge(ref_edge), .fb_edge(fb_edge),
      .up(up_o), .dn(dn_o), .close(close));

   spc_lock_det #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_lock (
      .clk(clk), .rst_n(rst_n), .enable(enable), .busy(up_o | dn_o), .close(close),
      .win(lock_win_i), .locked(locked_o));
endmodule

// File: rtl/spc_chk.sv
module spc_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic ref_edge,
   input logic fb_edge,
   input logic close,
   input logic up_o,
   input logic dn_o,
   input logic locked_o
);
   // R4
   up_dn_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(up_o && dn_o));
   // R2
   up_from_ref_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(up_o) |-> $past(ref_edge));
   // R3
   dn_from_fb_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(dn_o) |-> $past(fb_edge));
   // R2
   up_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(up_o) |-> $past(fb_edge || !enable));
   // R7
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> (!up_o && !dn_o && !locked_o));
   // R8
   lock_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked_o) |-> $past(close && enable));
endmodule

bind spd_phase_cmp spc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .ref_edge(ref_edge), .fb_edge(fb_edge),
   .close(close), .up_o(up_o), .dn_o(dn_o), .locked_o(locked_o));

// File: tb/spd_phase_cmp_tb_top.sv
`timescale 1ns/1ps
module spd_phase_cmp_tb_top;
   localparam int FILT  = 4;
   localparam int RUN   = 4;
   localparam int CW    = 12;
   localparam int WIN   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic ref_clk_i = 1'b1;
   logic fb_i = 1'b0;
   logic [CW-1:0] lock_win_i = CW'(WIN);
   logic up_o, dn_o, locked_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit mon = 0;
   int n_up = 0, n_dn = 0, n_both = 0;

   always #4 clk = ~clk;

   spd_phase_cmp #(.FILT_LEN(FILT), .CNT_W(CW), .LOCK_RUN(RUN)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ref_clk_i(ref_clk_i), .fb_i(fb_i),
      .lock_win_i(lock_win_i), .up_o(up_o), .dn_o(dn_o), .locked_o(locked_o));

   always @(negedge clk) if (mon) begin
      if (up_o) n_up++;
      if (dn_o) n_dn++;
      if (up_o && dn_o) n_both++;
   end

   function automatic int exp_up(bit ref_first, int d);
      return ref_first ? d : 0;
   endfunction
   function automatic int exp_dn(bit ref_first, int d);
      return ref_first ? 0 : d;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic clear_mon();
      n_up = 0; n_dn = 0; n_both = 0; mon = 1;
   endtask

   // one comparison: leading edge, then lagging edge d cycles later; then idle restore
   task automatic pair(bit ref_first, int d);
      clear_mon();
      if (ref_first) ref_clk_i = 1'b0; else fb_i = 1'b1;
      step(d);
      if (ref_first) fb_i = 1'b1; else ref_clk_i = 1'b0;
      step(d + FILT + 10);
      ref_clk_i = 1'b1;
      fb_i = 1'b0;
      step(FILT + 8);
      mon = 0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      step(3);
      @(negedge clk);
      check("R1 up", up_o, 0);
      check("R1 dn", dn_o, 0);
      check("R1 locked", locked_o, 0);
      rst_n = 1'b1;
      step(2);
      enable = 1'b1;
      step(FILT + 6);

      // R2 / R3 directed widths
      pair(1, 7);
      check("R2 up width", n_up, 7);
      check("R2 no dn", n_dn, 0);
      pair(0, 5);
      check("R3 dn width", n_dn, 5);
      check("R3 no up", n_up, 0);
      pair(1, 1);
      check("R2 width one", n_up, 1);
      // R4 coincident
      pair(1, 0);
      check("R4 coincident up", n_up, 0);
      check("R4 coincident dn", n_dn, 0);

      // R5 ignored edge polarities
      clear_mon();
      ref_clk_i = 1'b0; fb_i = 1'b1;
      step(FILT + 8);
      check("R5 setup no pulse", n_up + n_dn, 0);
      clear_mon();
      ref_clk_i = 1'b1; fb_i = 1'b0;
      step(FILT + 10);
      mon = 0;
      check("R5 ref rise fb fall ignored", n_up + n_dn, 0);

      // R6 chatter rejection
      clear_mon();
      ref_clk_i = 1'b0; step(FILT - 1); ref_clk_i = 1'b1;
      step(FILT + 8);
      check("R6 ref glitch", n_up, 0);
      fb_i = 1'b1; step(FILT - 1); fb_i = 1'b0;
      step(FILT + 8);
      mon = 0;
      check("R6 fb glitch", n_dn, 0);
      pair(1, 3);
      check("R6 full width accepted", n_up, 3);

      // R7 disable mid-pulse
      ref_clk_i = 1'b0;
      step(FILT + 6);
      @(negedge clk);
      check("R7 pulse open", up_o, 1);
      step(0);
      enable = 1'b0;
      step(1);
      @(negedge clk);
      check("R7 up dropped", up_o, 0);
      fb_i = 1'b1;
      step(FILT + 6);
      enable = 1'b1;
      clear_mon();
      step(FILT + 10);
      check("R7 edge while stopped", n_up + n_dn, 0);
      ref_clk_i = 1'b1; fb_i = 1'b0;
      step(FILT + 8);
      mon = 0;

      // R8 / R9 lock
      for (int i = 0; i < RUN - 1; i++) pair(1, 3);
      @(negedge clk);
      check("R8 not yet locked", locked_o, 0);
      pair(0, 0);
      @(negedge clk);
      check("R8 locked after run", locked_o, 1);
      pair(1, WIN + 2);
      @(negedge clk);
      check("R9 wide pulse unlocks", locked_o, 0);
      for (int i = 0; i < RUN; i++) pair(0, WIN - 1);
      @(negedge clk);
      check("R8 window minus one locks", locked_o, 1);
      pair(1, WIN);
      @(negedge clk);
      check("R9 width equal window unlocks", locked_o, 0);
      step(0);
      enable = 1'b0;
      step(2);
      @(negedge clk);
      check("R7 locked cleared", locked_o, 0);
      enable = 1'b1;
      step(2);

      // random separations
      for (int i = 0; i < 30; i++) begin
         bit rf;
         int d;
         rf = bit'($urandom_range(0, 1));
         d = int'($urandom_range(0, 40));
         pair(rf, d);
         check(rf ? "R2 random up" : "R3 random dn", rf ? n_up : n_dn, rf ? exp_up(rf, d) : exp_dn(rf, d));
         check("R4 random other side", rf ? n_dn : n_up, 0);
         check("R4 random overlap", n_both, 0);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule